// File: doc/BRIEF.md
# Four-State Shared Wire Resolver

This block computes the value seen on one shared wire that several sources drive at once. Each source offers one of four logic levels: a strong 0, a strong 1, high impedance (Z) or unknown (X). The block folds all of them into a single four-state result. A source that is in high impedance does not affect the wire. Two sources that disagree, or any source that is unknown, make the wire unknown.

A parameter selects a weak pull-up on the wire. With it, a wire that no source drives reads as 1 and never as Z. A second parameter adds a register stage at the output. Without it the result is purely combinational. With it the result is captured on the rising clock edge, and a synchronous reset sets it to X. The block is meant for four-state bus models inside larger designs and for checking tri-state sharing rules.

The level coding on every port is 2'b00 = 0, 2'b01 = 1, 2'b10 = Z and 2'b11 = X. Driver i occupies bits [2i+1:2i] of the packed input.

Top module: `wire_resolver`

## Requirements
- R1: The result is 0 (2'b00) when at least one driver gives 0 (2'b00), no driver gives 1 (2'b01), and no driver gives X (2'b11). Drivers giving Z (2'b10) do not affect it.
- R2: The result is 1 (2'b01) when at least one driver gives 1, no driver gives 0, and no driver gives X. Drivers giving Z do not affect it.
- R3: With the pull-up off, the result is Z (2'b10) exactly when every driver gives Z.
- R4: When one driver gives 0 and another gives 1 and no driver gives X, the result is X (2'b11).
- R5: When any driver gives X, the result is X, whatever the other drivers give.
- R6: With the pull-up on (PULLUP=1), the result is never Z. A result that would be Z under R3 is 1 (2'b01) instead. All other results are as in R1, R2, R4 and R5.
- R7: With REGISTERED=1, the output takes the resolved value of the inputs sampled at a rising clock edge and holds it until the next edge. A change of input between edges does not reach the output.
- R8: With REGISTERED=1, a rising edge with rst high sets the output to X (2'b11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the assertions |
| rst | input | 1 | Synchronous reset, active high; sets the registered output to X |
| drv_in | input | 2*N_DRV | Packed driver levels; driver i is in bits [2i+1:2i] |
| res_out | output | 2 | Resolved wire level, in the same four-state coding |

## Verification
The assertions assume that every driver field holds a valid two-bit code, that the inputs are stable around the rising edge, and that rst is high at the first edge so the register starts from a known X. The bench changes the inputs only on falling edges. It holds reset across the first rising edge and walks every combination of a three-driver wire, so each property sees all driver mixes. A single-driver instance covers the smallest legal width.

// File: rtl/wres_pkg.sv
package wres_pkg;

  localparam logic [1:0] LV_0 = 2'b00;
  localparam logic [1:0] LV_1 = 2'b01;
  localparam logic [1:0] LV_Z = 2'b10;
  localparam logic [1:0] LV_X = 2'b11;

  // Fold the wire-wide flags into one level.
  // Unknown wins first, then conflict, then a single strong value.
  function automatic logic [1:0] resolve_flags(
    input logic any0,
    input logic any1,
    input logic anyx,
    input logic allz
  );
    logic [1:0] r;
    if (anyx)              r = LV_X;
    else if (any0 && any1) r = LV_X;
    else if (any0)         r = LV_0;
    else if (any1)         r = LV_1;
    else if (allz)         r = LV_Z;
    else                   r = LV_X;
    return r;
  endfunction

  // A weak pull-up turns an undriven wire into a 1.
  function automatic logic [1:0] apply_pullup(
    input logic [1:0] lvl,
    input logic       en
  );
    return (en && (lvl == LV_Z)) ? LV_1 : lvl;
  endfunction

endpackage

// File: rtl/drv_decode.sv
module drv_decode
  import wres_pkg::*;
(
  input  logic [1:0] code,
  output logic       is0,
  output logic       is1,
  output logic       isz,
  output logic       isx
);

  always_comb begin
    is0 = 1'b0;
    is1 = 1'b0;
    isz = 1'b0;
    isx = 1'b0;
    unique case (code)
      LV_0:    is0 = 1'b1;
      LV_1:    is1 = 1'b1;
      LV_Z:    isz = 1'b1;
      default: isx = 1'b1;
    endcase
  end

endmodule

// File: rtl/drv_reduce.sv
module drv_reduce #(
  parameter int N = 4
) (
  input  logic [N-1:0] is0,
  input  logic [N-1:0] is1,
  input  logic [N-1:0] isz,
  input  logic [N-1:0] isx,
  output logic         any0,
  output logic         any1,
  output logic         anyx,
  output logic         allz
);

  assign any0 = |is0;
  assign any1 = |is1;
  assign anyx = |isx;
  assign allz = &isz;

endmodule

// File: rtl/wire_resolver.sv
module wire_resolver
  import wres_pkg::*;
#(
  parameter int N_DRV      = 4,
  parameter bit PULLUP     = 1'b0,
  parameter bit REGISTERED = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*N_DRV-1:0] drv_in,
  output logic [1:0]         res_out
);

  localparam int IN_W = 2 * N_DRV;

  logic [N_DRV-1:0] f_is0;
  logic [N_DRV-1:0] f_is1;
  logic [N_DRV-1:0] f_isz;
  logic [N_DRV-1:0] f_isx;
  logic             w_any0;
  logic             w_any1;
  logic             w_anyx;
  logic             w_allz;
  logic [1:0]       raw_lvl;
  logic [1:0]       final_lvl;

  initial begin
    if (N_DRV < 1) $error("wire_resolver: N_DRV must be at least 1 (IN_W=%0d)", IN_W);
  end

  // Per-driver classification.
  generate
    for (genvar i = 0; i < N_DRV; i++) begin : g_dec
      drv_decode u_dec (
        .code (drv_in[2*i +: 2]),
        .is0  (f_is0[i]),
        .is1  (f_is1[i]),
        .isz  (f_isz[i]),
        .isx  (f_isx[i])
      );
    end
  endgenerate

  // Wire-wide flags.
  drv_reduce #(.N(N_DRV)) u_red (
    .is0  (f_is0),
    .is1  (f_is1),
    .isz  (f_isz),
    .isx  (f_isx),
    .any0 (w_any0),
    .any1 (w_any1),
    .anyx (w_anyx),
    .allz (w_allz)
  );

  assign raw_lvl   = resolve_flags(w_any0, w_any1, w_anyx, w_allz);
  assign final_lvl = apply_pullup(raw_lvl, PULLUP);

  // Resolution rules checked against the flags.
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (raw_lvl == LV_0) |-> (w_any0 && !w_any1 && !w_anyx)); // R1
  AST_ONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (raw_lvl == LV_1) |-> (w_any1 && !w_any0 && !w_anyx)); // R2
  AST_Z_ALL_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (raw_lvl == LV_Z) |-> (w_allz && !w_any0 && !w_any1)); // R3
  AST_X_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (raw_lvl == LV_X) |-> (w_anyx || (w_any0 && w_any1))); // R4
  AST_CONFLICT_X: assert property (@(posedge clk) disable iff (rst)
    (w_any0 && w_any1) |-> (raw_lvl == LV_X)); // R4
  AST_X_FORCES_X: assert property (@(posedge clk) disable iff (rst)
    w_anyx |-> (raw_lvl == LV_X)); // R5

  // Output stage: pass-through or a register.
  generate
    if (REGISTERED) begin : g_reg
      logic [1:0] q_lvl;
      always_ff @(posedge clk) begin
        if (rst) q_lvl <= LV_X;
        else     q_lvl <= final_lvl;
      end
      assign res_out = q_lvl;

      AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_out == $past(final_lvl))); // R7
      AST_RST_TO_X: assert property (@(posedge clk)
        $past(rst) |-> (res_out == LV_X)); // R8
    end else begin : g_comb
      assign res_out = final_lvl;
    end
  endgenerate

  generate
    if (PULLUP) begin : g_pu_chk
      AST_PULL_NO_Z: assert property (@(posedge clk) disable iff (rst)
        res_out != LV_Z); // R6
      AST_PULL_FLOAT_ONE: assert property (@(posedge clk) disable iff (rst)
        (w_allz && !REGISTERED) |-> (res_out == LV_1)); // R6
    end
  endgenerate

endmodule

// File: tb/wire_resolver_test.sv
`timescale 1ns/1ps
module wire_resolver_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] drv3 = 6'b101010;
  logic [1:0] drv1 = 2'b10;
  logic [1:0] out_c;
  logic [1:0] out_r;
  logic [1:0] out_1;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  wire_resolver #(.N_DRV(3), .PULLUP(1'b0), .REGISTERED(1'b0)) uut (
    .clk(clk), .rst(rst), .drv_in(drv3), .res_out(out_c));
  wire_resolver #(.N_DRV(3), .PULLUP(1'b1), .REGISTERED(1'b1)) uut_pu (
    .clk(clk), .rst(rst), .drv_in(drv3), .res_out(out_r));
  wire_resolver #(.N_DRV(1), .PULLUP(1'b0), .REGISTERED(1'b0)) uut_one (
    .clk(clk), .rst(rst), .drv_in(drv1), .res_out(out_1));

  // Reference: count each level, then apply the rules in order.
  function automatic logic [1:0] ref_level(input logic [5:0] v, input int n, input bit pu);
    int c0 = 0, c1 = 0, cx = 0;
    for (int k = 0; k < n; k++) begin
      case (v[2*k +: 2])
        2'b00: c0++;
        2'b01: c1++;
        2'b11: cx++;
        default: ;
      endcase
    end
    if (cx > 0) return 2'b11;
    if (c0 > 0 && c1 > 0) return 2'b11;
    if (c0 > 0) return 2'b00;
    if (c1 > 0) return 2'b01;
    return pu ? 2'b01 : 2'b10;
  endfunction

  function automatic string tag_of(input logic [5:0] v, input int n, input bit pu);
    int c0 = 0, c1 = 0, cx = 0;
    for (int k = 0; k < n; k++) begin
      if (v[2*k +: 2] == 2'b00) c0++;
      if (v[2*k +: 2] == 2'b01) c1++;
      if (v[2*k +: 2] == 2'b11) cx++;
    end
    if (cx > 0) return "R5";
    if (c0 > 0 && c1 > 0) return "R4";
    if (c0 > 0) return "R1";
    if (c1 > 0) return "R2";
    return pu ? "R6" : "R3";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check("R8", "registered output after reset", out_r, 2'b11);
    @(negedge clk);
    drv3 = 6'b000000;
    @(posedge clk); #1;
    check("R8", "reset held over driven input", out_r, 2'b11);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_exhaustive_comb();
    for (int v = 0; v < 64; v++) begin
      @(negedge clk);
      drv3 = v[5:0];
      #1;
      check(tag_of(v[5:0], 3, 1'b0), $sformatf("comb drivers=%b", v[5:0]),
            out_c, ref_level(v[5:0], 3, 1'b0));
    end
  endtask

  task automatic t_exhaustive_reg();
    logic [1:0] prev;
    @(negedge clk);
    drv3 = 6'b101010;
    @(posedge clk); #1;
    check("R6", "registered all float", out_r, 2'b01);
    prev = out_r;
    for (int v = 0; v < 64; v++) begin
      @(negedge clk);
      drv3 = v[5:0];
      #1;
      check("R7", $sformatf("hold before edge drivers=%b", v[5:0]), out_r, prev);
      @(posedge clk); #1;
      check(tag_of(v[5:0], 3, 1'b1), $sformatf("reg pull-up drivers=%b", v[5:0]),
            out_r, ref_level(v[5:0], 3, 1'b1));
      check("R6", "pull-up never Z", {out_r == 2'b10, 1'b0}, 2'b00);
      prev = out_r;
    end
  endtask

  task automatic t_single();
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      drv1 = v[1:0];
      #1;
      check(tag_of({4'b1010, v[1:0]}, 1, 1'b0), $sformatf("single driver=%b", v[1:0]),
            out_1, ref_level({4'b1010, v[1:0]}, 1, 1'b0));
    end
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    drv3 = 6'b010101;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R8", "reset during operation", out_r, 2'b11);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R2", "after reset release", out_r, 2'b01);
  endtask

  initial begin
    t_reset();
    t_exhaustive_comb();
    t_single();
    t_exhaustive_reg();
    t_mid_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule